// File: doc/BRIEF.md
# Averaging SPI ADC Scan Sequencer

This block runs one burst of conversions on a serial touchscreen-style ADC. A start pulse takes a snapshot of an 8-bit channel enable mask. The block then walks the enabled channels from the lowest address to the highest. For each one it sends a group of 24-bit SPI frames. Every frame is a command byte followed by a 16-bit response, and the 12-bit conversion sits inside that response. All groups of one scan share a single chip-select window.

Each channel has its own 8-bit skip count and its own 8-bit oversample count. The first frames of a group fall inside the input's settling window, and the skip count says how many of them to drop. The frames that follow are summed, and the sum is divided by the oversample count with the quotient rounded up. The result goes out with its channel number and a one-cycle valid strobe. A done pulse closes the scan.

The command byte keeps the converter powered between frames and clears the power bit only on the last frame of a group. For the temperature, battery and auxiliary inputs it selects single-ended mode. For those same inputs it turns the internal reference on whenever no external reference is flagged.

Top module: `touch_adc_scanner`

## Requirements
- R1: A frame is exactly 24 SCLK cycles. MOSI carries the command byte MSB first, followed by 16 zero bits. The sample is taken from bits 14 down to 3 of the 16-bit response, which is shifted in MSB first.
- R2: The command byte has bit 7 = 1, bits 6:4 = channel address and bit 3 = 0. Bit 2 is single-ended, bit 1 is reference on and bit 0 is power kept.
- R3: Channel addresses 0, 2, 6 and 7 set bit 2. They also set bit 1 when `extRef` is low. All other channels clear both bits.
- R4: Within a group, every frame except the last sets bit 0. The last frame clears it.
- R5: A channel's group length is its skip count plus its effective oversample count. An oversample count of 0 counts as 1.
- R6: The result is ceil(sum of the non-skipped samples / effective oversample count). It appears on `resultData` with `resultChan` during a one-cycle `resultValid` pulse.
- R7: Enabled channels are converted in ascending address order. `csN` falls once per non-empty scan and stays low until the last result has been produced.
- R8: SPI runs in mode 0. SCLK idles low and is active only while `csN` is low. MOSI changes on falling edges and MISO is sampled on rising edges. Each SCLK half period lasts `HALF_DIV` clocks.
- R9: With an all-zero enable mask, `scanDone` is high in the cycle after the start pulse, and `csN` never goes low.
- R10: `scanDone` is a one-cycle pulse per scan. A start pulse that arrives while a scan is running has no effect.
- R11: The 20-bit accumulator holds 255 samples of 4095 without overflow, so that case averages to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begins a scan |
| chanEnable | input | 8 | Channel enable mask, bit n for address n |
| skipCounts | input | 64 | Per-channel settling frames to drop, 8 bits per channel, channel n at [8n+7:8n] |
| overCounts | input | 64 | Per-channel oversample count, same packing |
| extRef | input | 1 | External reference present |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to ADC |
| miso | input | 1 | SPI data from ADC |
| csN | output | 1 | SPI chip select, active low |
| resultData | output | 12 | Averaged result |
| resultChan | output | 3 | Channel of the current result |
| resultValid | output | 1 | Result strobe |
| scanDone | output | 1 | End-of-scan pulse |

## Verification
The assertions check the following on every cycle:
- SCLK never runs outside the chip-select window.
- Chip select is released only with SCLK low and no frame in flight.
- The accumulator never carries out.
- A quotient never exceeds 12 bits.
- A result appears only when a group's division finishes.
- The done pulse lasts one cycle.
- An empty mask finishes at once.

Only the bench scenarios can show the rest. These are the exact command byte of every frame, the skipping of settling frames, the rounded-up averages, the order of channels, and the frame and SCLK counts. They also include the all-maximum 255-sample case and a start pulse that is ignored during a scan.

// File: rtl/touch_adc_pkg.sv
package touch_adc_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CMD_BITS   = 8;
  localparam int SAMPLE_W   = 12;
  localparam int DATA_LSB   = 3;
  localparam int CNT_W      = 8;
  localparam int NUM_CH     = 8;
  localparam int CH_W       = 3;
  localparam int ACC_W      = SAMPLE_W + CNT_W;
  // Channels that need single-ended mode (and internal reference when no external one)
  localparam logic [NUM_CH-1:0] SE_CHAN_MASK = 8'b1100_0101;

  typedef struct packed {
    logic                csOn;
    logic                csOff;
    logic                loadFrame;
    logic [CMD_BITS-1:0] cmdByte;
    logic                clearAcc;
    logic                accum;
    logic                startDiv;
  } ctrl_strobe_t;
endpackage

// File: rtl/touch_adc_dp.sv
module touch_adc_dp
  import touch_adc_pkg::*;
#(
  parameter int HALF_DIV = 34
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        ctl,
  input  logic [CNT_W-1:0]    divisor,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                csN,
  output logic                frameDone,
  output logic                divDone,
  output logic [SAMPLE_W-1:0] resultData
);
  localparam int HALF_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam int RESP_W = FRAME_BITS - CMD_BITS;
  localparam int NUM_W  = ACC_W + 1;
  localparam int ITER_W = $clog2(NUM_W + 1);

  logic [HALF_W-1:0]     halfCnt;
  logic [FRAME_BITS-1:0] txShift;
  logic [RESP_W-1:0]     rxShift;
  logic [BIT_W-1:0]      bitCnt;
  logic                  busy;
  logic                  halfTick;
  logic [SAMPLE_W-1:0]   sample;

  assign halfTick = busy && (halfCnt == HALF_W'(HALF_DIV - 1));
  assign mosi     = txShift[FRAME_BITS-1];
  assign sample   = rxShift[DATA_LSB +: SAMPLE_W];

  // SPI mode-0 frame engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt   <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      bitCnt    <= '0;
      busy      <= 1'b0;
      sclk      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (ctl.loadFrame) begin
        txShift <= {ctl.cmdByte, {RESP_W{1'b0}}};
        bitCnt  <= '0;
        busy    <= 1'b1;
        halfCnt <= '0;
        sclk    <= 1'b0;
      end else if (busy) begin
        if (halfTick) begin
          halfCnt <= '0;
          sclk    <= ~sclk;
          if (!sclk) begin
            rxShift <= {rxShift[RESP_W-2:0], miso};
          end else begin
            txShift <= txShift << 1;
            if (bitCnt == BIT_W'(FRAME_BITS - 1)) begin
              busy      <= 1'b0;
              frameDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          csN <= 1'b1;
    else if (ctl.csOn)  csN <= 1'b0;
    else if (ctl.csOff) csN <= 1'b1;
  end

  // Sample accumulator
  logic [ACC_W-1:0] acc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             acc <= '0;
    else if (ctl.clearAcc) acc <= '0;
    else if (ctl.accum)    acc <= acc + ACC_W'(sample);
  end

  // Restoring divider on (acc + divisor - 1) for a rounded-up quotient
  logic [NUM_W-1:0]  quo;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W:0]    remTry;
  logic [ITER_W-1:0] iter;
  logic              dividing;

  assign remTry = {rem, quo[NUM_W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo      <= '0;
      rem      <= '0;
      iter     <= '0;
      dividing <= 1'b0;
      divDone  <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (ctl.startDiv) begin
        quo      <= {1'b0, acc} + NUM_W'(divisor) - NUM_W'(1);
        rem      <= '0;
        iter     <= ITER_W'(NUM_W);
        dividing <= 1'b1;
      end else if (dividing) begin
        if (remTry >= {1'b0, divisor}) begin
          rem <= CNT_W'(remTry - {1'b0, divisor});
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= remTry[CNT_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        iter <= iter - 1'b1;
        if (iter == ITER_W'(1)) begin
          dividing <= 1'b0;
          divDone  <= 1'b1;
        end
      end
    end
  end

  assign resultData = quo[SAMPLE_W-1:0];

  assert_sclk_in_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);
  assert_cs_release_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (!busy && !sclk));
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accum |-> ((({1'b0, acc} + (ACC_W+1)'(sample)) >> ACC_W) == 0));
  assert_quot_fits_R6: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> (quo[NUM_W-1:SAMPLE_W] == '0));
endmodule

// File: rtl/touch_adc_ctrl.sv
module touch_adc_ctrl
  import touch_adc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  input  logic [NUM_CH-1:0]       chanEnable,
  input  logic [NUM_CH*CNT_W-1:0] skipCounts,
  input  logic [NUM_CH*CNT_W-1:0] overCounts,
  input  logic                    extRef,
  input  logic                    frameDone,
  input  logic                    divDone,
  output ctrl_strobe_t            ctl,
  output logic [CNT_W-1:0]        divisor,
  output logic [CH_W-1:0]         resultChan,
  output logic                    scanDone
);
  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_LOAD, S_FRAME, S_DIVGO, S_DIVWAIT, S_DONE
  } state_t;

  state_t            state;
  logic [NUM_CH-1:0] maskReg;
  logic [CH_W:0]     scanIdx;
  logic [CH_W-1:0]   curChan;
  logic [CNT_W:0]    frameIdx;

  logic [CNT_W-1:0]    skipSel, overRaw, overEff;
  logic [CNT_W:0]      groupLen;
  logic                lastFrame, settled, singleEnd;
  logic [CMD_BITS-1:0] cmd;
  logic                pickHit;

  always_comb begin
    skipSel   = skipCounts[curChan*CNT_W +: CNT_W];
    overRaw   = overCounts[curChan*CNT_W +: CNT_W];
    overEff   = (overRaw == '0) ? CNT_W'(1) : overRaw;
    groupLen  = {1'b0, skipSel} + {1'b0, overEff};
    lastFrame = (frameIdx == groupLen - 1'b1);
    settled   = (frameIdx >= {1'b0, skipSel});
    singleEnd = SE_CHAN_MASK[curChan];
    cmd       = {1'b1, curChan, 1'b0, singleEnd, singleEnd & ~extRef, ~lastFrame};
    pickHit   = !scanIdx[CH_W] && maskReg[scanIdx[CH_W-1:0]];
  end

  always_comb begin
    ctl         = '0;
    ctl.cmdByte = cmd;
    case (state)
      S_IDLE:  ctl.csOn      = startPulse && (chanEnable != '0);
      S_PICK:  ctl.clearAcc  = pickHit;
      S_LOAD:  ctl.loadFrame = 1'b1;
      S_FRAME: ctl.accum     = frameDone && settled;
      S_DIVGO: ctl.startDiv  = 1'b1;
      S_DONE:  ctl.csOff     = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      maskReg  <= '0;
      scanIdx  <= '0;
      curChan  <= '0;
      frameIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (startPulse) begin
          if (chanEnable == '0) begin
            state <= S_DONE;
          end else begin
            maskReg <= chanEnable;
            scanIdx <= '0;
            state   <= S_PICK;
          end
        end
        S_PICK: begin
          if (scanIdx[CH_W]) begin
            state <= S_DONE;
          end else if (pickHit) begin
            curChan  <= scanIdx[CH_W-1:0];
            frameIdx <= '0;
            state    <= S_LOAD;
          end else begin
            scanIdx <= scanIdx + 1'b1;
          end
        end
        S_LOAD: state <= S_FRAME;
        S_FRAME: if (frameDone) begin
          if (lastFrame) begin
            state <= S_DIVGO;
          end else begin
            frameIdx <= frameIdx + 1'b1;
            state    <= S_LOAD;
          end
        end
        S_DIVGO: state <= S_DIVWAIT;
        S_DIVWAIT: if (divDone) begin
          scanIdx <= scanIdx + 1'b1;
          state   <= S_PICK;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign divisor    = overEff;
  assign resultChan = curChan;
  assign scanDone   = (state == S_DONE);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);
  assert_result_at_group_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> (state == S_DIVWAIT));
  assert_frame_in_group_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (frameIdx < groupLen));
  assert_empty_finishes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startPulse && chanEnable == '0) |=> scanDone);
endmodule

// File: rtl/touch_adc_scanner.sv
module touch_adc_scanner
  import touch_adc_pkg::*;
#(
  parameter int HALF_DIV = 34
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [7:0]  chanEnable,
  input  logic [63:0] skipCounts,
  input  logic [63:0] overCounts,
  input  logic        extRef,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csN,
  output logic [11:0] resultData,
  output logic [2:0]  resultChan,
  output logic        resultValid,
  output logic        scanDone
);
  ctrl_strobe_t     ctlBus;
  logic [CNT_W-1:0] divisor;
  logic             frameDone;
  logic             divDone;

  touch_adc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .chanEnable (chanEnable),
    .skipCounts (skipCounts),
    .overCounts (overCounts),
    .extRef     (extRef),
    .frameDone  (frameDone),
    .divDone    (divDone),
    .ctl        (ctlBus),
    .divisor    (divisor),
    .resultChan (resultChan),
    .scanDone   (scanDone)
  );

  touch_adc_dp #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctlBus),
    .divisor    (divisor),
    .miso       (miso),
    .sclk       (sclk),
    .mosi       (mosi),
    .csN        (csN),
    .frameDone  (frameDone),
    .divDone    (divDone),
    .resultData (resultData)
  );

  assign resultValid = divDone;
endmodule

// File: tb/touch_adc_scanner_bench.sv
`timescale 1ns/1ps
module touch_adc_scanner_bench;
  localparam int HALF     = 2;
  localparam int WATCHDOG = 190000;
  // {mask, skipBase, overBase, extRef}
  localparam logic [24:0] VEC [5] = '{
    {8'h01, 8'd1, 8'd2, 1'b0},
    {8'hA5, 8'd0, 8'd0, 1'b0},
    {8'hFF, 8'd2, 8'd1, 1'b1},
    {8'h5A, 8'd1, 8'd3, 1'b0},
    {8'h80, 8'd0, 8'd4, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [7:0] chanEnable = '0;
  logic [63:0] skipCounts = '0, overCounts = '0;
  logic extRef = 1'b0;
  logic sclk, mosi, csN, resultValid, scanDone;
  logic miso = 1'b0;
  logic [11:0] resultData;
  logic [2:0] resultChan;

  always #2.5 clk = ~clk;

  touch_adc_scanner #(.HALF_DIV(HALF)) u_touch_adc_scanner (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chanEnable(chanEnable),
    .skipCounts(skipCounts), .overCounts(overCounts), .extRef(extRef),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN),
    .resultData(resultData), .resultChan(resultChan),
    .resultValid(resultValid), .scanDone(scanDone));

  int checkCnt = 0, failCnt = 0;
  int cyc = 0;
  bit allMax = 1'b0;

  // ADC model
  int sBit = 0, sFrame = 0, riseCnt = 0, lastRise = 0, minPeriod = 1000000;
  logic [7:0]  sCmd = '0;
  logic [15:0] sResp = '0;
  logic [7:0]  cmdLog [512];

  // Output monitor
  int resCnt = 0, doneCnt = 0, csFallCnt = 0;
  logic [2:0]  resChanLog [16];
  logic [11:0] resDataLog [16];

  function automatic logic [11:0] smpVal(int ch, int g);
    if (allMax) return 12'hFFF;
    return 12'((ch * 300 + g * 37 + 11) % 4096);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge sclk) begin
    if (cyc - lastRise < minPeriod) minPeriod = cyc - lastRise;
    lastRise = cyc;
    riseCnt++;
    sCmd = {sCmd[6:0], mosi};
    sBit++;
    if (sBit == 8) begin
      if (sFrame < 512) cmdLog[sFrame] = sCmd;
      sResp = {1'b0, smpVal(int'(sCmd[6:4]), sFrame), 3'b000};
      sFrame++;
    end
    if (sBit == 24) sBit = 0;
  end

  always @(negedge sclk) begin
    if (sBit >= 8 && sBit < 24) miso <= sResp[23 - sBit];
  end

  always @(negedge csN) csFallCnt++;

  always @(negedge clk) begin
    if (resultValid) begin
      if (resCnt < 16) begin
        resChanLog[resCnt] = resultChan;
        resDataLog[resCnt] = resultData;
      end
      resCnt++;
    end
    if (scanDone) doneCnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runScan(input logic [7:0] mask, input bit extraStart);
    int d0, f0, t, g, ri;
    @(negedge clk);
    chanEnable = mask;
    sBit = 0; sFrame = 0; riseCnt = 0; resCnt = 0; minPeriod = 1000000;
    d0 = doneCnt; f0 = csFallCnt;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (extraStart) begin
      repeat (300) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    t = 0;
    while (doneCnt == d0 && t < 60000) begin @(negedge clk); t++; end
    repeat (200) @(negedge clk);
    check(doneCnt - d0 == 1, "R10 one done pulse per scan", doneCnt - d0, 1);
    check(csFallCnt - f0 == 1, "R7 single CS window", csFallCnt - f0, 1);
    g = 0; ri = 0;
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        int sk, n, sum, expv;
        bit se;
        logic [7:0] ec;
        sk = int'(skipCounts[ch*8 +: 8]);
        n  = int'(overCounts[ch*8 +: 8]);
        if (n == 0) n = 1;
        se = (ch == 0 || ch == 2 || ch == 6 || ch == 7);
        sum = 0;
        for (int f = 0; f < sk + n; f++) begin
          ec = {1'b1, 3'(ch), 1'b0, se, se & ~extRef, (f != sk + n - 1)};
          if (g < sFrame)
            check(cmdLog[g] == ec, "R2 R3 R4 command byte", int'(cmdLog[g]), int'(ec));
          if (f >= sk) sum += int'(smpVal(ch, g));
          g++;
        end
        expv = (sum + n - 1) / n;
        if (ri < resCnt && ri < 16) begin
          check(int'(resChanLog[ri]) == ch, "R7 ascending channel order", int'(resChanLog[ri]), ch);
          check(int'(resDataLog[ri]) == expv, "R6 rounded-up average", int'(resDataLog[ri]), expv);
        end
        ri++;
      end
    end
    check(sFrame == g, "R5 frame count", sFrame, g);
    check(riseCnt == 24 * g, "R1 SCLK cycles per frame", riseCnt, 24 * g);
    check(resCnt == ri, "R6 result count", resCnt, ri);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL R10 watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // Reset state
    check(csN == 1'b1, "R7 reset csN high", int'(csN), 1);
    check(sclk == 1'b0, "R8 reset SCLK low", int'(sclk), 0);
    check(scanDone == 1'b0 && resultValid == 1'b0, "R10 reset strobes low",
          int'(scanDone) + int'(resultValid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Table-driven scans
    for (int i = 0; i < 5; i++) begin
      logic [7:0] m, sb, ob;
      m  = VEC[i][24:17];
      sb = VEC[i][16:9];
      ob = VEC[i][8:1];
      extRef = VEC[i][0];
      for (int ch = 0; ch < 8; ch++) begin
        skipCounts[ch*8 +: 8] = sb + 8'(ch & 1);
        overCounts[ch*8 +: 8] = ob + 8'(ch % 3);
      end
      runScan(m, i == 2);
      if (i == 0) check(minPeriod == 2 * HALF, "R8 SCLK period", minPeriod, 2 * HALF);
    end

    // Empty mask: immediate done, no chip select
    begin
      int f0;
      f0 = csFallCnt;
      @(negedge clk);
      chanEnable = 8'h00;
      startPulse = 1'b1;
      @(negedge clk);
      check(scanDone == 1'b1, "R9 done one cycle after start", int'(scanDone), 1);
      startPulse = 1'b0;
      repeat (20) @(negedge clk);
      check(csFallCnt == f0 && csN == 1'b1, "R9 csN untouched", csFallCnt - f0, 0);
    end

    // Full-scale 255-sample average
    allMax = 1'b1;
    skipCounts = '0;
    overCounts = '0;
    overCounts[3*8 +: 8] = 8'd255;
    runScan(8'h08, 1'b0);
    check(resDataLog[0] == 12'hFFF, "R11 full-scale average", int'(resDataLog[0]), 4095);
    allMax = 1'b0;

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule